// File: doc/BRIEF.md
# Accumulator Rounding Saturating Readout

This block narrows a bank of wide lane accumulators into one packed 64-bit word. Two lane formats share the same 192-bit accumulator bus. In halfword format it holds four 48-bit accumulators that become four 16-bit results. In byte format it holds eight 24-bit accumulators that become eight 8-bit results. For each lane the accumulator is shifted right by an amount, rounded with the chosen rule, and saturated to the range of the destination lane.

Each lane's shift amount comes from one of three places: its own lane of a shift vector, a single element of that vector broadcast to every lane, or a small immediate broadcast to every lane. Combinations that make no sense produce a flag instead of a defined value, so the issuing logic can report them. The result appears one clock after the request and then holds until the next request.

Top module: `acc_round_readout`

## Requirements
- R1: Every cycle with `in_valid` high is followed one cycle later by `out_valid` high carrying that request's result. A cycle with `in_valid` low gives `out_valid` low in the next cycle, and `result` and `unpredictable` keep their previous values whatever the other inputs do.
- R2: When `fmt`=0 (halfword), lane i reads `acc[48i+47:48i]` and writes `result[16i+15:16i]`. When `fmt`=1 (byte), lane i reads `acc[24i+23:24i]` and writes `result[8i+7:8i]`.
- R3: `sh_src` selects the shift amount. Value 0 takes each lane's own field of `sh_vec`. Value 1 broadcasts the field numbered `sh_idx` (halfword format uses only its low two bits). Value 2 broadcasts `sh_imm`, zero-extended. Value 3 is reserved: the result is all zeros and `unpredictable` is 1. Halfword shift fields are 16-bit two's complement; byte shift fields are 8-bit unsigned.
- R4: Truncating modes add no rounding increment. Mode 4 (signed) shifts the accumulator arithmetically and saturates to [-32768, 32767]. Mode 5 (unsigned) shifts the accumulator as an unsigned value and saturates to the all-ones lane value.
- R5: Nearest-away modes add bit s-1 of the accumulator to the shifted value when s>0. Mode 1 (unsigned) always does this. Mode 0 (signed) does this for a non-negative accumulator. For a negative accumulator, mode 0 increments only when bit s-1 is set and at least one bit below it is set. Mode 0 then saturates like mode 4, and mode 1 like mode 5.
- R6: Nearest-even modes (2 signed, 3 unsigned) increment when bit s-1 is set and a lower bit is set. On an exact tie (bit s-1 set, all lower bits clear) they add the shifted value's least significant bit. They saturate like modes 4 and 5.
- R7: Halfword shift limits. Modes 2 and 4 give 0 for s>47. All other modes give 0 for s>48. At s=48, mode 1 gives accumulator bit 47, and modes 3 and 5 give 1 exactly when the unsigned accumulator exceeds 2^47.
- R8: Byte shift limits. Mode 5 gives 0 for s>=24. Modes 1 and 3 give 0 for s>24. At s=24, mode 1 gives accumulator bit 23, and mode 3 gives 1 exactly when the unsigned accumulator exceeds 2^23.
- R9: In halfword format with a valid mode, a lane whose shift amount is negative outputs 16'hDEAD and sets `unpredictable`. The other lanes are computed normally.
- R10: Modes 6 and 7 in either format, and the signed modes 0, 2 and 4 in byte format, output all zeros with `unpredictable` set to 1.
- R11: After reset, `out_valid`, `result` and `unpredictable` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Request strobe |
| fmt | input | 1 | Lane format: 0 halfword, 1 byte |
| mode | input | 3 | Rounding mode, 0 to 5 |
| sh_src | input | 2 | Shift source: 0 per-lane vector, 1 broadcast element, 2 immediate, 3 reserved |
| sh_idx | input | 3 | Element number for broadcast element |
| sh_vec | input | 64 | Packed shift fields |
| sh_imm | input | 5 | Immediate shift amount |
| acc | input | 192 | Packed lane accumulators |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Packed rounded and saturated lanes |
| unpredictable | output | 1 | Set for a negative halfword shift or an invalid combination |

## Verification
The bound checker watches every cycle for the one-cycle latency, the holding of the result while idle, the zero-and-flag response to reserved sources and invalid modes, the poison pattern in lane 0 for a negative per-lane shift, and the absence of the flag for valid byte requests and immediate halfword shifts. The rounding results themselves, including tie handling, saturation, and the shift-limit behaviour at and past the full accumulator width, can only be shown by the bench's scenarios. The bench compares those against a model that uses floor division and remainder arithmetic.

// File: rtl/acc_rnd_pkg.sv
package acc_rnd_pkg;
  // Rounding mode codes; bit 0 set means unsigned interpretation.
  localparam logic [2:0] RM_AWAY_S  = 3'd0;
  localparam logic [2:0] RM_AWAY_U  = 3'd1;
  localparam logic [2:0] RM_EVEN_S  = 3'd2;
  localparam logic [2:0] RM_EVEN_U  = 3'd3;
  localparam logic [2:0] RM_TRUNC_S = 3'd4;
  localparam logic [2:0] RM_TRUNC_U = 3'd5;

  // Shift operand sources.
  localparam logic [1:0] SRC_VEC  = 2'd0;
  localparam logic [1:0] SRC_ELEM = 2'd1;
  localparam logic [1:0] SRC_IMM  = 2'd2;
  localparam logic [1:0] SRC_RSVD = 2'd3;

  // Lane formats.
  localparam logic FMT_HALF = 1'b0;
  localparam logic FMT_BYTE = 1'b1;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/shamt_route.sv
module shamt_route
  import acc_rnd_pkg::*;
#(
  parameter int HL    = 4,
  parameter int HW    = 16,
  parameter int BL    = 8,
  parameter int BW    = 8,
  parameter int IW    = 5,
  parameter int IDX_W = 3
) (
  input  logic [HL*HW-1:0] vec,
  input  logic [IW-1:0]    imm,
  input  logic [1:0]       src,
  input  logic [IDX_W-1:0] idx,
  output logic [HL*HW-1:0] hw_sh,
  output logic [BL*BW-1:0] by_sh
);
  localparam int HIX = $clog2(HL);

  logic [HW-1:0] h_elem;
  logic [BW-1:0] b_elem;

  assign h_elem = vec[idx[HIX-1:0]*HW +: HW];
  assign b_elem = vec[idx*BW +: BW];

  for (genvar i = 0; i < HL; i++) begin : g_half
    always_comb begin
      unique case (src)
        SRC_VEC:  hw_sh[i*HW +: HW] = vec[i*HW +: HW];
        SRC_ELEM: hw_sh[i*HW +: HW] = h_elem;
        SRC_IMM:  hw_sh[i*HW +: HW] = HW'(imm);
        default:  hw_sh[i*HW +: HW] = '0;
      endcase
    end
  end

  for (genvar i = 0; i < BL; i++) begin : g_byte
    always_comb begin
      unique case (src)
        SRC_VEC:  by_sh[i*BW +: BW] = vec[i*BW +: BW];
        SRC_ELEM: by_sh[i*BW +: BW] = b_elem;
        SRC_IMM:  by_sh[i*BW +: BW] = BW'(imm);
        default:  by_sh[i*BW +: BW] = '0;
      endcase
    end
  end
endmodule

// File: rtl/rnd_lane.sv
module rnd_lane
  import acc_rnd_pkg::*;
#(
  parameter int            AW             = 48,
  parameter int            RW             = 16,
  parameter int            SW             = 16,
  parameter bit            SH_SIGNED      = 1'b1,
  parameter bit            FULL_TRUNC_CMP = 1'b1,
  parameter logic [RW-1:0] POISON         = '0
) (
  input  logic [AW-1:0] acc,
  input  logic [SW-1:0] shamt,
  input  logic [2:0]    mode,
  output logic [RW-1:0] res,
  output logic          neg_shift
);
  localparam int EW = AW + 2;
  localparam int CW = $clog2(AW + 1);
  localparam logic [SW:0] LIM_FULL  = (SW+1)'(AW);
  localparam logic [SW:0] LIM_SHORT = (SW+1)'(AW - 1);
  localparam logic signed [EW-1:0] S_MAX = {{(EW-RW+1){1'b0}}, {(RW-1){1'b1}}};
  localparam logic signed [EW-1:0] S_MIN = {{(EW-RW+1){1'b1}}, {(RW-1){1'b0}}};
  localparam logic signed [EW-1:0] U_MAX = {{(EW-RW){1'b0}}, {RW{1'b1}}};
  localparam logic [AW-1:0] MID = {1'b1, {(AW-1){1'b0}}};

  logic sgn_mode, is_away, is_even, acc_neg;
  logic beyond, full_trunc, rbit, sticky, inc;
  logic [SW:0]   sh_ext;
  logic [CW-1:0] sh;
  logic signed [EW-1:0] ext, shifted, rounded, clamped;
  logic [EW-1:0] below, half;
  logic unused_hi;

  always_comb begin
    sgn_mode   = ~mode[0];
    is_away    = (mode[2:1] == 2'b00);
    is_even    = (mode[2:1] == 2'b01);
    acc_neg    = acc[AW-1];
    neg_shift  = SH_SIGNED && shamt[SW-1];
    sh_ext     = {1'b0, shamt};
    // Signed nearest-even and truncation stop one position earlier.
    beyond     = (sgn_mode && !is_away) ? (sh_ext > LIM_SHORT) : (sh_ext > LIM_FULL);
    full_trunc = FULL_TRUNC_CMP && (mode == RM_TRUNC_U) && (sh_ext == LIM_FULL);
    sh         = shamt[CW-1:0];

    ext     = sgn_mode ? $signed({{2{acc_neg}}, acc}) : $signed({2'b00, acc});
    shifted = ext >>> sh;
    below   = (EW'(1) << sh) - EW'(1);
    half    = below ^ (below >> 1);
    rbit    = |(ext & half);
    sticky  = |(ext & (below >> 1));

    if (is_away)      inc = (sgn_mode && acc_neg) ? (rbit && sticky) : rbit;
    else if (is_even) inc = rbit && (sticky || shifted[0]);
    else              inc = 1'b0;

    rounded = shifted + $signed({{(EW-1){1'b0}}, inc});
    clamped = rounded;
    if (sgn_mode) begin
      if (!acc_neg && (rounded > S_MAX))     clamped = S_MAX;
      else if (acc_neg && (rounded < S_MIN)) clamped = S_MIN;
    end else if (rounded > U_MAX) begin
      clamped = U_MAX;
    end

    if (neg_shift)       res = POISON;
    else if (full_trunc) res = {{(RW-1){1'b0}}, (acc > MID)};
    else if (beyond)     res = '0;
    else                 res = clamped[RW-1:0];
  end

  assign unused_hi = ^clamped[EW-1:RW];
endmodule

// File: rtl/acc_round_readout.sv
module acc_round_readout
  import acc_rnd_pkg::*;
#(
  parameter int HL    = 4,
  parameter int HAW   = 48,
  parameter int HRW   = 16,
  parameter int BL    = 8,
  parameter int BAW   = 24,
  parameter int BRW   = 8,
  parameter int IMM_W = 5,
  localparam int ACC_W = HL * HAW,
  localparam int OUT_W = HL * HRW,
  localparam int IDX_W = $clog2(BL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             fmt,
  input  logic [2:0]       mode,
  input  logic [1:0]       sh_src,
  input  logic [IDX_W-1:0] sh_idx,
  input  logic [OUT_W-1:0] sh_vec,
  input  logic [IMM_W-1:0] sh_imm,
  input  logic [ACC_W-1:0] acc,
  output logic             out_valid,
  output logic [OUT_W-1:0] result,
  output logic             unpredictable
);
  logic             srst_n;
  logic [OUT_W-1:0] h_sh, b_sh, h_res, b_res, res_d, res_q;
  logic [HL-1:0]    h_neg;
  logic [BL-1:0]    unused_b_neg;
  logic             combo_bad, unp_d, unp_q, vld_q;

  rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  shamt_route #(
    .HL(HL), .HW(HRW), .BL(BL), .BW(BRW), .IW(IMM_W), .IDX_W(IDX_W)
  ) u_route (
    .vec   (sh_vec),
    .imm   (sh_imm),
    .src   (sh_src),
    .idx   (sh_idx),
    .hw_sh (h_sh),
    .by_sh (b_sh)
  );

  for (genvar i = 0; i < HL; i++) begin : g_hlane
    rnd_lane #(
      .AW(HAW), .RW(HRW), .SW(HRW),
      .SH_SIGNED(1'b1), .FULL_TRUNC_CMP(1'b1), .POISON(HRW'(16'hDEAD))
    ) u_lane (
      .acc       (acc[i*HAW +: HAW]),
      .shamt     (h_sh[i*HRW +: HRW]),
      .mode      (mode),
      .res       (h_res[i*HRW +: HRW]),
      .neg_shift (h_neg[i])
    );
  end

  for (genvar i = 0; i < BL; i++) begin : g_blane
    rnd_lane #(
      .AW(BAW), .RW(BRW), .SW(BRW),
      .SH_SIGNED(1'b0), .FULL_TRUNC_CMP(1'b0), .POISON('0)
    ) u_lane (
      .acc       (acc[i*BAW +: BAW]),
      .shamt     (b_sh[i*BRW +: BRW]),
      .mode      (mode),
      .res       (b_res[i*BRW +: BRW]),
      .neg_shift (unused_b_neg[i])
    );
  end

  // Next-state selection.
  always_comb begin
    combo_bad = (mode > RM_TRUNC_U) || (sh_src == SRC_RSVD) ||
                ((fmt == FMT_BYTE) && !mode[0]);
    if (combo_bad) begin
      res_d = '0;
      unp_d = 1'b1;
    end else if (fmt == FMT_BYTE) begin
      res_d = b_res;
      unp_d = 1'b0;
    end else begin
      res_d = h_res;
      unp_d = |h_neg;
    end
  end

  // Output registers, loaded only on a request.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      unp_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        unp_q <= unp_d;
      end
    end
  end

  assign out_valid     = vld_q;
  assign result        = res_q;
  assign unpredictable = unp_q;
endmodule

// File: rtl/acc_round_readout_chk.sv
module acc_round_readout_chk #(
  parameter int OUT_W = 64
) (
  input logic             clk,
  input logic             srst_n,
  input logic             in_valid,
  input logic             fmt,
  input logic [2:0]       mode,
  input logic [1:0]       sh_src,
  input logic [OUT_W-1:0] sh_vec,
  input logic             out_valid,
  input logic [OUT_W-1:0] result,
  input logic             unpredictable
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!srst_n)
    in_valid |=> out_valid);

  a_r1_idle_clears: assert property (@(posedge clk) disable iff (!srst_n)
    !in_valid |=> !out_valid);

  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!srst_n)
    !in_valid |=> ($stable(result) && $stable(unpredictable)));

  a_r10_bad_mode: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && (mode > 3'd5)) |=> (unpredictable && (result == '0)));

  a_r10_byte_signed: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && fmt && !mode[0]) |=> (unpredictable && (result == '0)));

  a_r3_reserved_src: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && (sh_src == 2'd3)) |=> (unpredictable && (result == '0)));

  a_r9_poison_lane0: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && !fmt && (mode <= 3'd5) && (sh_src == 2'd0) && sh_vec[15])
    |=> (unpredictable && (result[15:0] == 16'hDEAD)));

  a_r9_imm_no_flag: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && !fmt && (mode <= 3'd5) && (sh_src == 2'd2)) |=> !unpredictable);

  a_r8_byte_no_flag: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && fmt && mode[0] && (mode <= 3'd5) && (sh_src != 2'd3))
    |=> !unpredictable);
endmodule

bind acc_round_readout acc_round_readout_chk #(.OUT_W(OUT_W)) u_chk (
  .clk           (clk),
  .srst_n        (srst_n),
  .in_valid      (in_valid),
  .fmt           (fmt),
  .mode          (mode),
  .sh_src        (sh_src),
  .sh_vec        (sh_vec),
  .out_valid     (out_valid),
  .result        (result),
  .unpredictable (unpredictable)
);

// File: tb/acc_round_readout_tb.sv
module acc_round_readout_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, fmt;
  logic [2:0]   mode;
  logic [1:0]   sh_src;
  logic [2:0]   sh_idx;
  logic [63:0]  sh_vec;
  logic [4:0]   sh_imm;
  logic [191:0] acc;
  logic         out_valid, unpredictable;
  logic [63:0]  result;

  typedef struct {
    logic [63:0] res;
    logic        unp;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  acc_round_readout u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .mode(mode),
    .sh_src(sh_src), .sh_idx(sh_idx), .sh_vec(sh_vec), .sh_imm(sh_imm),
    .acc(acc), .out_valid(out_valid), .result(result),
    .unpredictable(unpredictable)
  );

  // Model: floor quotient plus remainder comparison against half a step.
  function automatic longint ref_lane(logic [47:0] raw, int aw, int rw, int s, int m);
    longint v, qt, rem, half, r, hi, lo;
    bit sgnm;
    sgnm = (m % 2) == 0;
    if (aw == 48) v = sgnm ? longint'($signed(raw)) : longint'({16'd0, raw});
    else          v = sgnm ? longint'($signed(raw[23:0])) : longint'({40'd0, raw[23:0]});
    if (sgnm && m != 0 && s > aw - 1) return 0;
    if (s > aw) return 0;
    if (m == 5 && s == aw) return (aw == 48 && v > (64'sd1 <<< 47)) ? 1 : 0;
    qt = v >>> s;
    rem = v - (qt <<< s);
    half = (s > 0) ? (64'sd1 <<< (s - 1)) : 0;
    r = qt;
    if (s > 0) begin
      if (m == 0)      r = qt + (((v >= 0) ? (rem >= half) : (rem > half)) ? 1 : 0);
      else if (m == 1) r = qt + ((rem >= half) ? 1 : 0);
      else if (m == 2 || m == 3) begin
        if (rem > half)       r = qt + 1;
        else if (rem == half) r = qt + (qt & 1);
      end
    end
    if (sgnm) begin hi = (64'sd1 <<< (rw - 1)) - 1; lo = -(64'sd1 <<< (rw - 1)); end
    else begin hi = (64'sd1 <<< rw) - 1; lo = 0; end
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r & ((64'sd1 <<< rw) - 1);
  endfunction

  function automatic void ref_vec(input logic [191:0] a, input logic f, input logic [2:0] m,
                                  input logic [1:0] src, input logic [2:0] ix,
                                  input logic [63:0] v, input logic [4:0] im,
                                  output logic [63:0] r, output logic u);
    r = '0;
    u = 1'b0;
    if (m > 3'd5 || src == 2'd3 || (f && !m[0])) begin
      u = 1'b1;
      return;
    end
    if (!f) begin
      for (int i = 0; i < 4; i++) begin
        logic [15:0] raw;
        int s;
        raw = (src == 2'd0) ? v[16*i +: 16] : (src == 2'd1) ? v[16*ix[1:0] +: 16] : {11'd0, im};
        s = int'($signed(raw));
        if (s < 0) begin
          r[16*i +: 16] = 16'hDEAD;
          u = 1'b1;
        end else r[16*i +: 16] = 16'(ref_lane(a[48*i +: 48], 48, 16, s, int'(m)));
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        logic [7:0] raw8;
        raw8 = (src == 2'd0) ? v[8*i +: 8] : (src == 2'd1) ? v[8*ix +: 8] : {3'd0, im};
        r[8*i +: 8] = 8'(ref_lane({24'd0, a[24*i +: 24]}, 24, 8, int'(raw8), int'(m)));
      end
    end
  endfunction

  // Driver: applies one request and queues its expected outcome.
  task automatic send(input logic [191:0] a, input logic f, input logic [2:0] m,
                      input logic [1:0] src, input logic [2:0] ix, input logic [63:0] v,
                      input logic [4:0] im, input string tag);
    exp_t e;
    @(negedge clk);
    acc = a; fmt = f; mode = m; sh_src = src; sh_idx = ix; sh_vec = v; sh_imm = im;
    in_valid = 1'b1;
    ref_vec(a, f, m, src, ix, v, im, e.res, e.unp);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: compare each produced result with the queue head.
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (q.size() == 0) check(1'b0, "R1 unexpected result", result, '0);
      else begin
        exp_t e;
        e = q.pop_front();
        check((result === e.res) && (unpredictable === e.unp), e.tag,
              {result[62:0], unpredictable}, {e.res[62:0], e.unp});
        if (result !== e.res)
          $display("  %s full result %h vs %h", e.tag, result, e.res);
      end
    end
  end

  function automatic logic [191:0] hw4(logic [47:0] a0, logic [47:0] a1,
                                       logic [47:0] a2, logic [47:0] a3);
    return {a3, a2, a1, a0};
  endfunction

  function automatic logic [63:0] sh4(int s0, int s1, int s2, int s3);
    return {16'(s3), 16'(s2), 16'(s1), 16'(s0)};
  endfunction

  function automatic logic [191:0] rnd192();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    logic        heldu;
    rst_n = 1'b0; in_valid = 1'b0; fmt = 1'b0; mode = '0; sh_src = '0;
    sh_idx = '0; sh_vec = '0; sh_imm = '0; acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid && result == '0 && !unpredictable, "R11 reset state",
          {result[62:0], out_valid}, '0);

    // R4 truncation, signed and unsigned, with saturation.
    send(hw4(48'd100, -48'sd100, 48'h7FFF_FFFF_FFFF, 48'h8000_0000_0000), 0, 3'd4, 2'd0, 0,
         sh4(2, 2, 4, 4), 0, "R4 trunc signed");
    send(hw4(48'd100, -48'sd100, 48'h0000_0012_3456, 48'd7), 0, 3'd5, 2'd0, 0,
         sh4(2, 2, 4, 40), 0, "R4 trunc unsigned");
    // R5 nearest-away ties and near-ties.
    send(hw4(48'd24, -48'sd24, -48'sd23, 48'd8), 0, 3'd0, 2'd0, 0, sh4(4, 4, 4, 4), 0,
         "R5 away signed");
    send(hw4(48'd24, -48'sd24, -48'sd23, 48'd8), 0, 3'd1, 2'd0, 0, sh4(4, 4, 4, 1), 0,
         "R5 away unsigned");
    // R6 nearest-even.
    send(hw4(48'd24, 48'd40, 48'd41, -48'sd24), 0, 3'd2, 2'd0, 0, sh4(4, 4, 4, 4), 0,
         "R6 even signed");
    send(hw4(48'd24, 48'd40, 48'd41, 48'd3), 0, 3'd3, 2'd0, 0, sh4(4, 4, 4, 1), 0,
         "R6 even unsigned");
    // R7 halfword shift limits.
    send(hw4(48'h8000_0000_0000, 48'h7FFF_FFFF_FFFF, 48'h8000_0000_0000, 48'hFFFF_FFFF_FFFF),
         0, 3'd1, 2'd0, 0, sh4(48, 48, 49, 47), 0, "R7 away unsigned edge");
    send(hw4(48'h8000_0000_0001, 48'h8000_0000_0000, 48'hFFFF_0000_0000, 48'hFFFF_FFFF_FFFF),
         0, 3'd5, 2'd0, 0, sh4(48, 48, 47, 49), 0, "R7 trunc unsigned edge");
    send(hw4(48'h8000_0000_0001, 48'h8000_0000_0000, 48'h8000_0000_0000, 48'hC000_0000_0000),
         0, 3'd3, 2'd0, 0, sh4(48, 48, 47, 49), 0, "R7 even unsigned edge");
    send(hw4(48'h8000_0000_0000, 48'h8000_0000_0001, 48'd5, 48'h8000_0000_0000),
         0, 3'd0, 2'd0, 0, sh4(48, 48, 48, 49), 0, "R7 away signed edge");
    send(hw4(-48'sd5, 48'h8000_0000_0000, 48'hC000_0000_0000, 48'd5),
         0, 3'd4, 2'd0, 0, sh4(47, 48, 47, 46), 0, "R7 trunc signed edge");
    send(hw4(48'hC000_0000_0000, 48'h8000_0000_0000, 48'h4000_0000_0000, 48'd5),
         0, 3'd2, 2'd0, 0, sh4(47, 48, 47, 46), 0, "R7 even signed edge");
    // R8 byte shift limits.
    send({24'h800001, 24'h800000, 24'hFFFFFF, 24'h7FFFFF, 24'h800000, 24'hFFFFFF,
          24'h800000, 24'h123456}, 1, 3'd1, 2'd0, 0,
         {8'd0, 8'd23, 8'd25, 8'd24, 8'd24, 8'd24, 8'd24, 8'd24}, 0, "R8 away byte edge");
    send({24'h800001, 24'h800000, 24'hFFFFFF, 24'h7FFFFF, 24'h800000, 24'hFFFFFF,
          24'h800000, 24'h123456}, 1, 3'd3, 2'd0, 0,
         {8'd24, 8'd24, 8'd25, 8'd23, 8'd24, 8'd24, 8'd16, 8'd200}, 0, "R8 even byte edge");
    send({24'hFFFFFF, 24'hFFFFFF, 24'h800000, 24'h800000, 24'h000123, 24'hFFFFFF,
          24'h000100, 24'h123456}, 1, 3'd5, 2'd0, 0,
         {8'd24, 8'd23, 8'd24, 8'd23, 8'd0, 8'd16, 8'd1, 8'd255}, 0, "R8 trunc byte edge");
    // R2 lane layout with distinct per-lane values.
    send({24'd7, 24'd300, 24'd64, 24'd255, 24'd1, 24'd1000, 24'd16, 24'd3}, 1, 3'd5, 2'd0, 0,
         {8'd0, 8'd1, 8'd2, 8'd0, 8'd0, 8'd2, 8'd3, 8'd1}, 0, "R2 byte lane layout");
    send(hw4(48'd1, 48'd200, 48'd3000, 48'd40000), 0, 3'd5, 2'd0, 0, sh4(0, 1, 2, 3), 0,
         "R2 halfword lane layout");
    // R9 negative halfword shift.
    send(hw4(48'd100, 48'd100, 48'd100, 48'd100), 0, 3'd4, 2'd0, 0,
         sh4(-1, 4, -32768, 2), 0, "R9 negative shift");
    // R10 invalid combinations.
    send(rnd192(), 0, 3'd6, 2'd0, 0, 64'd3, 0, "R10 mode 6");
    send(rnd192(), 1, 3'd7, 2'd0, 0, 64'd3, 0, "R10 mode 7 byte");
    send(rnd192(), 1, 3'd0, 2'd0, 0, 64'd3, 0, "R10 byte signed 0");
    send(rnd192(), 1, 3'd2, 2'd2, 0, 64'd3, 3, "R10 byte signed 2");
    send(rnd192(), 1, 3'd4, 2'd1, 0, 64'd3, 0, "R10 byte signed 4");
    // R3 shift source selection.
    send(rnd192(), 0, 3'd0, 2'd1, 3'd6, sh4(1, 9, 20, -3), 0, "R3 element halfword");
    send(rnd192(), 1, 3'd3, 2'd1, 3'd5, {8'd1, 8'd2, 8'd9, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8}, 0,
         "R3 element byte");
    send(rnd192(), 0, 3'd2, 2'd2, 3'd0, sh4(-1, -1, -1, -1), 5'd31, "R3 immediate halfword");
    send(rnd192(), 1, 3'd1, 2'd2, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 5'd7, "R3 immediate byte");
    send(rnd192(), 0, 3'd1, 2'd3, 3'd0, 64'd0, 5'd0, "R3 reserved source");
    go_idle();
    repeat (3) @(negedge clk);

    // R1 hold while idle with changing inputs.
    held = result;
    heldu = unpredictable;
    acc = rnd192(); mode = 3'd1; fmt = 1'b0; sh_vec = 64'h0101_0101_0101_0101;
    repeat (3) @(negedge clk);
    check(!out_valid && result === held && unpredictable === heldu, "R1 hold while idle",
          result, held);

    // Back-to-back pseudo-random requests across all modes and sources.
    for (int n = 0; n < 400; n++) begin
      logic [191:0] a;
      logic [63:0]  v;
      logic         f;
      logic [2:0]   m;
      logic [1:0]   src;
      string        tag;
      a = rnd192();
      if ($urandom_range(0, 1) == 0) a = a & {4{48'h0000_0000_FFFF}};
      f = 1'($urandom_range(0, 1));
      m = 3'($urandom_range(0, 7));
      if (f && $urandom_range(0, 3) != 0) m = {m[2:1], 1'b1};
      src = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      v = '0;
      for (int i = 0; i < 4; i++) begin
        int r;
        r = $urandom_range(0, 55);
        v[16*i +: 16] = (r > 52) ? 16'(-int'($urandom_range(1, 300))) : 16'(r);
      end
      if (f) for (int i = 0; i < 8; i++) v[8*i +: 8] = 8'($urandom_range(0, 27));
      if (m > 3'd5 || src == 2'd3 || (f && !m[0])) tag = "R10 random invalid";
      else if (m[2:1] == 2'b00) tag = "R5 random away";
      else if (m[2:1] == 2'b01) tag = "R6 random even";
      else tag = "R4 random trunc";
      send(a, f, m, src, 3'($urandom_range(0, 7)), v, 5'($urandom_range(0, 31)), tag);
      if ($urandom_range(0, 7) == 0) go_idle();
    end
    go_idle();
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R1 all results delivered", 64'(q.size()), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule